// File: doc/BRIEF.md
# LDPC Redundancy-Version Start Position Calculator

This block returns the starting offset k0 inside the LDPC circular buffer for a given redundancy version. A request carries the circular buffer length, the lifting size, a one-bit base-graph select and a two-bit redundancy version. The request is taken on a valid/ready handshake. Later the block shows the 16-bit k0 together with a one-cycle done strobe.

Three cases are resolved in the cycle that follows acceptance, and the block can take a new request in every cycle for them:
- redundancy version 0;
- a buffer length equal to the full mother-code length N;
- a lifting size of zero.

A limited-buffer request needs an integer division by N. That division runs on an internal restoring shift-subtract divider, which produces one quotient bit per cycle. Ready stays low for the whole of that fixed busy period.

Top module: `ldpc_k0_calc`

## Requirements
- R1: A request with redundancy version 0 returns k0 = 0, with done_o high in the cycle after acceptance, whatever the other inputs are.
- R2: The mother-code length is N = 66·Zc when bg_sel_i = 0 and N = 50·Zc when bg_sel_i = 1.
- R3: The numerator for redundancy versions 1, 2 and 3 is 17, 33 and 56 when bg_sel_i = 0, and 13, 25 and 43 when bg_sel_i = 1.
- R4: When ncb_i equals N and the redundancy version is not 0, k0 = numerator·Zc, with done_o high in the cycle after acceptance.
- R5: When ncb_i differs from N, Zc is not 0 and the redundancy version is not 0, k0 = floor(numerator·ncb_i / N)·Zc. The floor is applied before the multiplication by Zc.
- R6: A limited-buffer request with Zc = 0 returns k0 = 0 in the cycle after acceptance, without a division.
- R7: A request that needs the division holds req_ready_o low for exactly 23 cycles after acceptance. done_o and req_ready_o both go high in the cycle after that.
- R8: Requests that need no division keep req_ready_o high, so consecutive cycles each accept one request and each return one result.
- R9: bg_sel_i equals the base-graph number minus 1: 0 selects base graph 1 and 1 selects base graph 2.
- R10: k0_o is 0 after reset and changes only in a cycle where done_o is high.
- R11: req_valid_i is ignored while req_ready_o is low, whatever the other request inputs hold. Each accepted request produces exactly one done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| ncb_i | input | 16 | Circular buffer length |
| zc_i | input | 9 | Lifting size, 0 to 384 |
| bg_sel_i | input | 1 | Base graph minus 1 |
| rv_i | input | 2 | Redundancy version |
| done_o | output | 1 | One-cycle result strobe |
| k0_o | output | 16 | Start position, held between strobes |

## Verification
The bench builds the block with its default widths: a 16-bit buffer length, a 9-bit lifting size and a 16-bit result. The dividend is therefore 22 bits wide and the busy period is 23 cycles. These widths cover lifting sizes up to 384 and full-buffer lengths up to 25344 on both base graphs. Under them, each redundancy version and base-graph pair is driven with random lengths no greater than N, and with the edge cases: Zc of 0 and of 384, a length equal to N, a length of N-1 and a length of 0.

// File: rtl/ldpc_k0_pkg.sv
package ldpc_k0_pkg;
  localparam int unsigned NUM_W  = 6;  // widest numerator is 56
  localparam int unsigned MULT_W = 7;  // widest N factor is 66

  typedef enum logic {K0_IDLE, K0_DIV} k0_state_e;

  function automatic logic [NUM_W-1:0] rv_numerator(input logic bg_sel, input logic [1:0] rv);
    logic [NUM_W-1:0] r;
    unique case ({bg_sel, rv})
      3'b0_01: r = NUM_W'(17);
      3'b0_10: r = NUM_W'(33);
      3'b0_11: r = NUM_W'(56);
      3'b1_01: r = NUM_W'(13);
      3'b1_10: r = NUM_W'(25);
      3'b1_11: r = NUM_W'(43);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [MULT_W-1:0] n_factor(input logic bg_sel);
    return bg_sel ? MULT_W'(50) : MULT_W'(66);
  endfunction
endpackage

// File: rtl/k0_param_rom.sv
module k0_param_rom
  import ldpc_k0_pkg::*;
#(
  parameter int unsigned ZC_W = 9,
  localparam int unsigned N_W = MULT_W + ZC_W
) (
  input  logic             bg_sel_i,
  input  logic [1:0]       rv_i,
  input  logic [ZC_W-1:0]  zc_i,
  output logic [NUM_W-1:0] num_o,
  output logic [N_W-1:0]   n_len_o
);
  always_comb begin
    num_o   = rv_numerator(bg_sel_i, rv_i);
    n_len_o = N_W'(n_factor(bg_sel_i)) * N_W'(zc_i);
  end
endmodule

// File: rtl/k0_restoring_div.sv
module k0_restoring_div #(
  parameter int unsigned DVD_W = 22,
  parameter int unsigned DVS_W = 16,
  localparam int unsigned CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  logic [DVS_W:0]   rem_q;
  logic [DVD_W-1:0] acc_q;   // dividend shifts out, quotient shifts in
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [DVS_W:0]   trial;
  logic             ge;

  always_comb begin
    trial = {rem_q[DVS_W-1:0], acc_q[DVD_W-1]};
    ge    = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      acc_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      acc_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CNT_W'(DVD_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= ge ? (trial - {1'b0, dvs_q}) : trial;
      acc_q  <= {acc_q[DVD_W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = acc_q;
endmodule

// File: rtl/ldpc_k0_calc.sv
module ldpc_k0_calc
  import ldpc_k0_pkg::*;
#(
  parameter int unsigned NCB_W = 16,
  parameter int unsigned ZC_W  = 9,
  parameter int unsigned K0_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [NCB_W-1:0] ncb_i,
  input  logic [ZC_W-1:0]  zc_i,
  input  logic             bg_sel_i,
  input  logic [1:0]       rv_i,
  output logic             done_o,
  output logic [K0_W-1:0]  k0_o
);
  localparam int unsigned N_W    = MULT_W + ZC_W;
  localparam int unsigned CMP_W  = (N_W > NCB_W) ? N_W : NCB_W;
  localparam int unsigned DVD_W  = NUM_W + NCB_W;
  localparam int unsigned FAST_W = NUM_W + ZC_W;
  localparam int unsigned PROD_W = DVD_W + ZC_W;

  k0_state_e         state_q;
  logic              done_q;
  logic [K0_W-1:0]   k0_q;
  logic [ZC_W-1:0]   zc_q;
  logic [NUM_W-1:0]  num;
  logic [N_W-1:0]    n_len;
  logic              accept, rv_zero, full_buf, zc_zero, need_div;
  logic [K0_W-1:0]   fast_k0;
  logic [DVD_W-1:0]  dividend, quot;
  logic [PROD_W-1:0] scaled;
  logic              div_done;

  k0_param_rom #(.ZC_W(ZC_W)) u_rom (
    .bg_sel_i (bg_sel_i),
    .rv_i     (rv_i),
    .zc_i     (zc_i),
    .num_o    (num),
    .n_len_o  (n_len)
  );

  always_comb begin
    accept   = req_valid_i && (state_q == K0_IDLE);
    rv_zero  = (rv_i == 2'd0);
    full_buf = (CMP_W'(ncb_i) == CMP_W'(n_len));
    zc_zero  = (zc_i == '0);
    need_div = !rv_zero && !full_buf && !zc_zero;
    fast_k0  = (rv_zero || !full_buf) ? '0
             : K0_W'(FAST_W'(num) * FAST_W'(zc_i));
    dividend = DVD_W'(num) * DVD_W'(ncb_i);
    scaled   = PROD_W'(quot) * PROD_W'(zc_q);  // floor first, then scale
  end

  k0_restoring_div #(.DVD_W(DVD_W), .DVS_W(N_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept && need_div),
    .dividend_i (dividend),
    .divisor_i  (n_len),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= K0_IDLE;
      done_q  <= 1'b0;
      k0_q    <= '0;
      zc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        K0_IDLE: if (accept) begin
          if (need_div) begin
            state_q <= K0_DIV;
            zc_q    <= zc_i;
          end else begin
            k0_q   <= fast_k0;
            done_q <= 1'b1;
          end
        end
        K0_DIV: if (div_done) begin
          k0_q    <= K0_W'(scaled);
          done_q  <= 1'b1;
          state_q <= K0_IDLE;
        end
        default: state_q <= K0_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == K0_IDLE);
  assign done_o      = done_q;
  assign k0_o        = k0_q;
endmodule

// File: rtl/k0_calc_checker.sv
module k0_calc_checker #(
  parameter int unsigned NCB_W = 16,
  parameter int unsigned ZC_W  = 9,
  parameter int unsigned K0_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [NCB_W-1:0] ncb_i,
  input logic [ZC_W-1:0]  zc_i,
  input logic             bg_sel_i,
  input logic [1:0]       rv_i,
  input logic             done_o,
  input logic [K0_W-1:0]  k0_o
);
  localparam int unsigned BUSY_CYC = 6 + NCB_W + 1;

  int unsigned     num_ref, n_ref, busy_cnt;
  logic            acc, fast_req;
  logic [K0_W-1:0] full_ref, lim_ref, lim_q;

  always_comb begin
    case ({bg_sel_i, rv_i})
      3'b001: num_ref = 17; 3'b010: num_ref = 33; 3'b011: num_ref = 56;
      3'b101: num_ref = 13; 3'b110: num_ref = 25; 3'b111: num_ref = 43;
      default: num_ref = 0;
    endcase
    n_ref    = (bg_sel_i ? 50 : 66) * int'(zc_i);
    acc      = req_valid_i && req_ready_o;
    fast_req = (rv_i == 2'd0) || (int'(ncb_i) == n_ref) || (zc_i == '0);
    full_ref = K0_W'(num_ref * int'(zc_i));
    lim_ref  = (n_ref == 0) ? '0 : K0_W'(((num_ref * int'(ncb_i)) / n_ref) * int'(zc_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= 0;
      lim_q    <= '0;
    end else begin
      busy_cnt <= req_ready_o ? 0 : busy_cnt + 1;
      if (acc && !fast_req) lim_q <= lim_ref;
    end
  end

  p_rv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && rv_i == 2'd0 |=> done_o && k0_o == '0);

  p_full_buf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && rv_i != 2'd0 && int'(ncb_i) == n_ref |=> done_o && k0_o == $past(full_ref));

  p_limited_val_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> k0_o == lim_q);

  p_zc_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && rv_i != 2'd0 && zc_i == '0 && ncb_i != '0 |=> done_o && k0_o == '0);

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> busy_cnt == BUSY_CYC && done_o);

  p_fast_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && fast_req |=> req_ready_o);

  p_k0_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(k0_o));

  p_done_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(acc) || $past(!req_ready_o));
endmodule

bind ldpc_k0_calc k0_calc_checker #(.NCB_W(NCB_W), .ZC_W(ZC_W), .K0_W(K0_W)) u_k0_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .ncb_i       (ncb_i),
  .zc_i        (zc_i),
  .bg_sel_i    (bg_sel_i),
  .rv_i        (rv_i),
  .done_o      (done_o),
  .k0_o        (k0_o)
);

// File: tb/tb_ldpc_k0_calc.sv
module tb_ldpc_k0_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] ncb_i = '0;
  logic [8:0]  zc_i = '0;
  logic        bg_sel_i = 1'b0;
  logic [1:0]  rv_i = '0;
  logic        done_o;
  logic [15:0] k0_o;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_k0 = '0;
  bit          finished = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz
  always @(posedge clk_i) cycle <= cycle + 1;

  ldpc_k0_calc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .ncb_i(ncb_i), .zc_i(zc_i), .bg_sel_i(bg_sel_i), .rv_i(rv_i),
    .done_o(done_o), .k0_o(k0_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural model of the requirements (R2, R3, R9 tables)
  function automatic int model(input int ncb, input int zc, input int bg, input int rv, output string tag);
    int num, n;
    int t1[4] = '{0, 17, 33, 56};
    int t2[4] = '{0, 13, 25, 43};
    if (rv == 0) begin tag = "R1"; return 0; end
    num = (bg == 0) ? t1[rv] : t2[rv];
    n   = ((bg == 0) ? 66 : 50) * zc;
    if (ncb == n) begin tag = "R4"; return (num * zc) & 16'hffff; end
    if (zc == 0) begin tag = "R6"; return 0; end
    tag = "R5";
    return (((num * ncb) / n) * zc) & 16'hffff;
  endfunction

  // Driver: call at a negedge; returns at the negedge after acceptance
  task automatic send(input int ncb, input int zc, input int bg, input int rv);
    string tag;
    int e;
    logic r;
    e = model(ncb, zc, bg, rv, tag);
    req_valid_i = 1'b1;
    ncb_i = 16'(ncb); zc_i = 9'(zc); bg_sel_i = 1'(bg); rv_i = 2'(rv);
    exp_q.push_back(16'(e));
    tag_q.push_back(tag);
    forever begin
      r = req_ready_o;
      @(posedge clk_i);
      @(negedge clk_i);
      if (r) break;
    end
    req_valid_i = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected done", int'(k0_o), -1);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(k0_o == e, t, int'(k0_o), int'(e));
        end
        last_k0 = k0_o;
      end else begin
        check(k0_o == last_k0, "R10 hold", int'(k0_o), int'(last_k0));
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", cycle, 0);
    finish_run();
  end

  initial begin
    int n, c0, lows;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R10 reset ready", int'(req_ready_o), 1);
    check(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
    check(k0_o == '0, "R10 reset k0", int'(k0_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R3 R4 R5 R6 R9 sweep
    for (int bg = 0; bg < 2; bg++) begin
      for (int rv = 0; rv < 4; rv++) begin
        for (int t = 0; t < 10; t++) begin
          int zc, ncb;
          zc = (t == 0) ? 0 : (t == 1) ? 384 : 1 + int'($urandom % 384);
          n  = ((bg == 0) ? 66 : 50) * zc;
          if (t == 0)           ncb = (rv == 0) ? 500 : 321;   // R6 / R1
          else if (t % 4 == 1)  ncb = n;                         // R4
          else if (t % 4 == 2)  ncb = (n > 0) ? n - 1 : 0;       // R5 boundary
          else if (t == 3)      ncb = 0;                         // R5 zero length
          else                  ncb = int'($urandom % (n + 1));  // R5 random
          send(ncb, zc, bg, rv);
        end
      end
    end

    // R7: busy period of a limited-buffer request
    send(1000, 100, 0, 2);
    lows = 0;
    while (!req_ready_o && lows < 100) begin
      lows++;
      @(negedge clk_i);
    end
    check(lows == 23, "R7 busy length", lows, 23);
    check(done_o == 1'b1, "R7 done with ready", int'(done_o), 1);

    // R8: three fast requests in consecutive cycles
    c0 = cycle;
    send(0, 7, 1, 0);
    send(350, 7, 1, 3);
    send(77, 0, 0, 1);
    check(cycle - c0 == 3, "R8 back-to-back", cycle - c0, 3);

    // R11: valid while busy is ignored
    send(2000, 64, 1, 1);
    for (int i = 0; i < 6; i++) begin
      req_valid_i = 1'b1;
      rv_i = 2'(i); ncb_i = 16'(i * 9); zc_i = 9'(i + 3); bg_sel_i = 1'(i);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;

    n = 0;
    while ((exp_q.size() != 0 || !req_ready_o) && n < 200) begin
      n++;
      @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
    check(req_ready_o == 1'b1, "R11 idle after ignore", int'(req_ready_o), 1);
    finish_run();
  end
endmodule